// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block is the register-level model of a four-channel, byte-wide DMA controller with a page extension per channel. A host reaches its registers through an 8-bit write/read bus, with a 4-bit port offset and a separate page-select line. Each channel keeps a base and a current 16-bit address, a base and a current 16-bit count, an 8-bit page and a mode byte. The four channels share one mask nibble, one status byte and one low/high byte-pointer flip-flop.

A peripheral asks for a run of elements on a channel through a valid/ready request port. One cycle after the request is accepted, the block reports how many elements it granted. With that report it gives the 24-bit start address of the run, the transfer kind and the address direction. It also pulses a terminal-count flag when the channel's count runs out. The current address and count move forward by the granted amount. A channel in auto-initialise mode reloads itself from its base registers when it reaches terminal count. The block moves no data itself.

Top module: `dma4_regfile`

## Requirements
- R1: After reset the mask is 4'b1111, the status byte is 0 and the byte pointer selects the low byte. Every address, count, page and mode register is 0, and `xfer_ready` is 1.
- R2: With `reg_pgsel`=0, offsets 0..7 reach the channel registers. Offset {ch,0} is the address of channel ch and offset {ch,1} is its count. A write stores the low byte when the pointer is 0 and the high byte when it is 1, and the pointer then toggles. Writing the high byte also copies the completed 16-bit base value into the channel's current register. Writing only the low byte leaves the current register unchanged.
- R3: A read of offsets 0..7 returns the current (running) address or count, not the base value. It returns the low byte when the pointer is 0 and the high byte when it is 1, and the pointer then toggles. A write to offset 0xC clears the pointer.
- R4: With `reg_pgsel`=1, `reg_addr[1:0]` selects a channel's page register for both reads and writes. The page supplies bits 23:16 of `mem_addr`.
- R5: A write to offset 0xB stores the data byte as the mode of the channel named by data bits 1:0. In the mode byte, bits 7:6 = 01 select single mode and bit 5 = 1 makes the address count down. Bit 4 enables auto-initialise. Bits 3:2 give the kind: 00 verify, 01 write to memory, 10 read from memory, 11 illegal.
- R6: Offset 0xA sets (data bit 2 = 1) or clears (bit 2 = 0) the mask bit of channel data[1:0]. Offset 0xF loads the mask from data[3:0]. Offset 0xE clears the whole mask. Offset 0xD sets the mask to 4'b1111 and clears the pointer.
- R7: A request is rejected when the channel is masked, when its mode is not single, or when its kind is illegal. A rejected request is still answered, with a grant of 0, and it changes no address, count or status.
- R8: The grant is the smaller of the requested length and the current count. The count drops by the grant, and the address rises or falls by the grant times `ELEM_BYTES`, wrapping modulo 2^16.
- R9: When a nonzero grant brings the count to 0, `xfer_tc` pulses with the answer. The same event sets status bit ch and clears status bit ch+4. If bit 4 of the mode is set, the current address and count are reloaded from the base registers.
- R10: A read of offset 0x8 returns the status byte and clears bits 3:0; a terminal count in the same cycle still sets its bit. A write to offset 0x9 sets (data bit 2 = 1) or clears (bit 2 = 0) status bit 4+data[1:0].
- R11: A request is accepted on a clock edge where `xfer_valid` and `xfer_ready` are both 1. In the next cycle `xfer_done` is high for one cycle, with the grant, the page and start address on `mem_addr`, the kind on `mem_kind` and the direction on `mem_down`. `xfer_ready` is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (side effects at the clock edge) |
| reg_pgsel | input | 1 | Selects the page registers instead of the offset map |
| reg_addr | input | 4 | Port offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from `reg_addr` |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_ready | output | 1 | Request can be accepted |
| xfer_ch | input | 2 | Requesting channel |
| xfer_len | input | LEN_W | Requested element count |
| xfer_done | output | 1 | One-cycle answer strobe |
| xfer_grant | output | LEN_W | Elements granted |
| xfer_tc | output | 1 | Terminal count reached by this grant |
| mem_addr | output | PAGE_W+16 | Page and start address of the granted run |
| mem_kind | output | 2 | Transfer kind from the mode |
| mem_down | output | 1 | Address counts down |

## Verification
The assertions assume that the host never strobes `reg_rd` and `reg_wr` in the same cycle. They also assume that a host write to a channel's registers never lands on the edge where a request for that channel is accepted. The bench drives every host access and every request on its own falling edge, one at a time, with idle cycles between them, so these assumptions always hold. The stimulus keeps requests away from the wrap of the 16-bit count, and every channel is programmed through full low/high byte pairs after the pointer has been cleared.

// File: rtl/dma4_regfile.sv
module dma4_regfile #(
  parameter int LEN_W      = 16,
  parameter int PAGE_W     = 8,
  parameter int ELEM_BYTES = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic                 reg_pgsel,
  input  logic [3:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic                 xfer_valid,
  output logic                 xfer_ready,
  input  logic [1:0]           xfer_ch,
  input  logic [LEN_W-1:0]     xfer_len,
  output logic                 xfer_done,
  output logic [LEN_W-1:0]     xfer_grant,
  output logic                 xfer_tc,
  output logic [PAGE_W+15:0]   mem_addr,
  output logic [1:0]           mem_kind,
  output logic                 mem_down
);
  localparam int AW  = 16;
  localparam int NCH = 4;

  logic [AW-1:0]     base_a [NCH];
  logic [AW-1:0]     base_c [NCH];
  logic [AW-1:0]     cur_a  [NCH];
  logic [AW-1:0]     cur_c  [NCH];
  logic [PAGE_W-1:0] page_q [NCH];
  logic [7:0]        mode_q [NCH];
  logic [3:0]        mask_q;
  logic [7:0]        stat_q;
  logic              ff_q;

  logic [1:0]    hch;
  logic [AW-1:0] hval;
  assign hch  = reg_addr[2:1];
  assign hval = reg_addr[0] ? cur_c[hch] : cur_a[hch];

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_pgsel)
      reg_rdata = 8'(page_q[reg_addr[1:0]]);
    else if (!reg_addr[3])
      reg_rdata = ff_q ? hval[15:8] : hval[7:0];
    else if (reg_addr == 4'h8)
      reg_rdata = stat_q;
  end

  logic [7:0]    md;
  logic          ok, accept, hit;
  logic [AW-1:0] avail, grant, step, new_a, new_c;
  assign md     = mode_q[xfer_ch];
  assign ok     = !mask_q[xfer_ch] && md[7:6] == 2'b01 && md[3:2] != 2'b11;
  assign avail  = cur_c[xfer_ch];
  assign grant  = !ok ? '0 : (AW'(xfer_len) < avail ? AW'(xfer_len) : avail);
  assign step   = AW'(grant * ELEM_BYTES);
  assign new_a  = md[5] ? cur_a[xfer_ch] - step : cur_a[xfer_ch] + step;
  assign new_c  = avail - grant;
  assign hit    = grant != '0 && new_c == '0;
  assign xfer_ready = !xfer_done;
  assign accept = xfer_valid && xfer_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0; base_c[i] <= '0;
        cur_a[i]  <= '0; cur_c[i]  <= '0;
        page_q[i] <= '0; mode_q[i] <= '0;
      end
      mask_q     <= 4'hF;
      stat_q     <= '0;
      ff_q       <= 1'b0;
      xfer_done  <= 1'b0;
      xfer_grant <= '0;
      xfer_tc    <= 1'b0;
      mem_addr   <= '0;
      mem_kind   <= '0;
      mem_down   <= 1'b0;
    end else begin
      if (reg_rd && !reg_pgsel) begin
        if (!reg_addr[3]) ff_q <= !ff_q;
        else if (reg_addr == 4'h8) stat_q[3:0] <= '0;
      end

      if (reg_wr && reg_pgsel) begin
        page_q[reg_addr[1:0]] <= PAGE_W'(reg_wdata);
      end else if (reg_wr) begin
        if (!reg_addr[3]) begin
          ff_q <= !ff_q;
          if (reg_addr[0]) begin
            if (!ff_q) base_c[hch][7:0] <= reg_wdata;
            else begin
              base_c[hch][15:8] <= reg_wdata;
              cur_c[hch]        <= {reg_wdata, base_c[hch][7:0]};
            end
          end else begin
            if (!ff_q) base_a[hch][7:0] <= reg_wdata;
            else begin
              base_a[hch][15:8] <= reg_wdata;
              cur_a[hch]        <= {reg_wdata, base_a[hch][7:0]};
            end
          end
        end else begin
          case (reg_addr)
            4'h9: stat_q[{1'b1, reg_wdata[1:0]}] <= reg_wdata[2];
            4'hA: mask_q[reg_wdata[1:0]]         <= reg_wdata[2];
            4'hB: mode_q[reg_wdata[1:0]]         <= reg_wdata;
            4'hC: ff_q <= 1'b0;
            4'hD: begin ff_q <= 1'b0; mask_q <= 4'hF; end
            4'hE: mask_q <= 4'h0;
            4'hF: mask_q <= reg_wdata[3:0];
            default: ;
          endcase
        end
      end

      xfer_done <= accept;
      if (accept) begin
        xfer_grant <= LEN_W'(grant);
        xfer_tc    <= hit;
        mem_addr   <= {page_q[xfer_ch], cur_a[xfer_ch]};
        mem_kind   <= md[3:2];
        mem_down   <= md[5];
        if (grant != '0) begin
          cur_a[xfer_ch] <= new_a;
          cur_c[xfer_ch] <= new_c;
          if (hit) begin
            stat_q[{1'b0, xfer_ch}] <= 1'b1;
            stat_q[{1'b1, xfer_ch}] <= 1'b0;
            if (md[4]) begin
              cur_a[xfer_ch] <= base_a[xfer_ch];
              cur_c[xfer_ch] <= base_c[xfer_ch];
            end
          end
        end
      end else begin
        xfer_tc <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma4_regfile_chk.sv
module dma4_regfile_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic             reg_pgsel,
  input logic [3:0]       reg_addr,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic [1:0]       xfer_ch,
  input logic [LEN_W-1:0] xfer_len,
  input logic             xfer_done,
  input logic [LEN_W-1:0] xfer_grant,
  input logic             xfer_tc,
  input logic [3:0]       mask_q,
  input logic [7:0]       stat_q,
  input logic             ff_q
);
  p_grant_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> xfer_grant <= $past(xfer_len));

  p_masked_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && mask_q[xfer_ch]) |=> (xfer_done && xfer_grant == '0));

  p_tc_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_tc |-> (xfer_done && xfer_grant != '0));

  p_master_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_pgsel && reg_addr == 4'hD) |=> (mask_q == 4'hF && !ff_q));

  p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_pgsel && !reg_addr[3]) |=> ff_q != $past(ff_q));

  p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_pgsel && reg_addr == 4'h8 && !(xfer_valid && xfer_ready))
      |=> stat_q[3:0] == 4'h0);

  p_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> (xfer_done && !xfer_ready));
endmodule

bind dma4_regfile dma4_regfile_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_pgsel(reg_pgsel), .reg_addr(reg_addr), .xfer_valid(xfer_valid),
  .xfer_ready(xfer_ready), .xfer_ch(xfer_ch), .xfer_len(xfer_len),
  .xfer_done(xfer_done), .xfer_grant(xfer_grant), .xfer_tc(xfer_tc),
  .mask_q(mask_q), .stat_q(stat_q), .ff_q(ff_q)
);

// File: tb/dma4_regfile_bench.sv
module dma4_regfile_bench;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0, reg_pgsel = 0;
  logic [3:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0, reg_rdata;
  logic        xfer_valid = 0, xfer_ready;
  logic [1:0]  xfer_ch = 0;
  logic [15:0] xfer_len = 0, xfer_grant;
  logic        xfer_done, xfer_tc, mem_down;
  logic [23:0] mem_addr;
  logic [1:0]  mem_kind;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma4_regfile u_dma4_regfile (.*);

  // mode, base addr, base count, len, grant, cur addr after, cur count after, tc
  localparam logic [104:0] VEC [7] = '{
    {8'h45, 16'h1000, 16'h0010, 16'h0004, 16'h0004, 16'h1004, 16'h000C, 1'b0},
    {8'h66, 16'h2000, 16'h0100, 16'h0010, 16'h0010, 16'h1FF0, 16'h00F0, 1'b0},
    {8'h4B, 16'hFFF0, 16'h0005, 16'h0009, 16'h0005, 16'hFFF5, 16'h0000, 1'b1},
    {8'h50, 16'h0300, 16'h0003, 16'h0003, 16'h0003, 16'h0300, 16'h0003, 1'b1},
    {8'h05, 16'h4000, 16'h0008, 16'h0002, 16'h0000, 16'h4000, 16'h0008, 1'b0},
    {8'h4D, 16'h4000, 16'h0008, 16'h0002, 16'h0000, 16'h4000, 16'h0008, 1'b0},
    {8'h61, 16'h0002, 16'h0020, 16'h0004, 16'h0004, 16'hFFFE, 16'h001C, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic pg, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_pgsel = pg; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_pgsel = 0;
  endtask

  task automatic rd(input logic pg, input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_pgsel = pg; reg_addr = a;
    #5 d = reg_rdata;
    @(negedge clk); reg_rd = 0; reg_pgsel = 0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(0, a, v[7:0]); wr(0, a, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(0, 4'hC, 8'h00);
    rd(0, a, lo); rd(0, a, hi);
    v = {hi, lo};
  endtask

  task automatic xfer(input logic [1:0] ch, input logic [15:0] len,
                      output logic [15:0] g, output logic tc);
    @(negedge clk); xfer_valid = 1; xfer_ch = ch; xfer_len = len;
    @(negedge clk); xfer_valid = 0;
    #2;
    g = xfer_grant; tc = xfer_tc;
    check("R11 done strobe", {31'd0, xfer_done}, 32'd1);
    check("R11 ready low while answering", {31'd0, xfer_ready}, 32'd0);
    @(negedge clk);
    check("R11 done lasts one cycle", {31'd0, xfer_done}, 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v, g;
    logic t;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    #2 check("R1 ready after reset", {31'd0, xfer_ready}, 32'd1);
    rd(0, 4'h8, b); check("R1 status zero", {24'd0, b}, 32'h0);
    rd16(4'h0, v); check("R1 ch0 address zero", {16'd0, v}, 32'h0);
    rd(1, 4'h3, b); check("R1 page zero", {24'd0, b}, 32'h0);
    xfer(2'd0, 16'd1, g, t); check("R1 all channels masked", {16'd0, g}, 32'h0);

    // R5 R7 R8 R9 table of single transfers
    for (int i = 0; i < 7; i++) begin
      logic [7:0]  m;
      logic [1:0]  ch;
      m  = VEC[i][104:97];
      ch = m[1:0];
      wr(0, 4'hD, 8'h00);
      wr(0, 4'hE, 8'h00);
      wr(0, 4'hB, m);
      wr16({1'b0, ch, 1'b0}, VEC[i][96:81]);
      wr16({1'b0, ch, 1'b1}, VEC[i][80:65]);
      xfer(ch, VEC[i][64:49], g, t);
      check($sformatf("R8 R7 grant row %0d", i), {16'd0, g}, {16'd0, VEC[i][48:33]});
      check($sformatf("R9 tc row %0d", i), {31'd0, t}, {31'd0, VEC[i][0]});
      check($sformatf("R11 start address row %0d", i), {8'd0, mem_addr}, {16'd0, VEC[i][96:81]});
      check($sformatf("R5 kind row %0d", i), {30'd0, mem_kind}, {30'd0, m[3:2]});
      rd16({1'b0, ch, 1'b0}, v);
      check($sformatf("R8 R9 current address row %0d", i), {16'd0, v}, {16'd0, VEC[i][32:17]});
      rd16({1'b0, ch, 1'b1}, v);
      check($sformatf("R8 R9 current count row %0d", i), {16'd0, v}, {16'd0, VEC[i][16:1]});
    end

    // R4 page supplies upper address bits
    wr(0, 4'hD, 8'h00); wr(0, 4'hE, 8'h00);
    wr(0, 4'hB, 8'h46);
    wr(1, 4'h2, 8'hAB);
    wr16(4'h4, 16'h1234); wr16(4'h5, 16'h0040);
    xfer(2'd2, 16'd2, g, t);
    check("R4 mem_addr with page", {8'd0, mem_addr}, 32'h00AB1234);
    check("R5 write kind", {30'd0, mem_kind}, 32'h1);
    check("R5 upward", {31'd0, mem_down}, 32'h0);
    rd(1, 4'h2, b); check("R4 page readback", {24'd0, b}, 32'hAB);

    // R9 R10 status
    rd(0, 4'h8, b); check("R9 tc bits of ch3 and ch0", {24'd0, b}, 32'h09);
    rd(0, 4'h8, b); check("R10 read clears tc bits", {24'd0, b}, 32'h00);
    wr(0, 4'h9, 8'h06);
    rd(0, 4'h8, b); check("R10 software request bit", {24'd0, b}, 32'h40);
    xfer(2'd2, 16'h0100, g, t);
    check("R8 grant limited by count", {16'd0, g}, 32'h3E);
    check("R9 tc on ch2", {31'd0, t}, 32'd1);
    rd(0, 4'h8, b); check("R9 tc sets bit, clears request", {24'd0, b}, 32'h04);

    // R6 masks
    wr(0, 4'hE, 8'h00);
    wr(0, 4'hB, 8'h45);
    wr(0, 4'hC, 8'h00);
    wr16(4'h2, 16'h0100); wr16(4'h3, 16'h0010);
    wr(0, 4'hA, 8'h05);
    xfer(2'd1, 16'd4, g, t); check("R6 single mask set blocks", {16'd0, g}, 32'h0);
    rd16(4'h3, v); check("R7 masked request leaves count", {16'd0, v}, 32'h10);
    wr(0, 4'hA, 8'h01);
    xfer(2'd1, 16'd4, g, t); check("R6 single mask clear", {16'd0, g}, 32'h4);
    wr(0, 4'hF, 8'h02);
    xfer(2'd1, 16'd4, g, t); check("R6 write-all mask", {16'd0, g}, 32'h0);
    wr(0, 4'hF, 8'h00);
    xfer(2'd1, 16'd4, g, t); check("R6 write-all unmask", {16'd0, g}, 32'h4);
    rd16(4'h3, v); check("R8 count after two grants", {16'd0, v}, 32'h08);

    // R3 pointer clear between halves
    wr(0, 4'hC, 8'h00);
    rd(0, 4'h3, b);
    wr(0, 4'hC, 8'h00);
    rd(0, 4'h3, b); check("R3 clear pointer returns low byte", {24'd0, b}, 32'h08);

    // R2 high byte loads current, low byte alone does not
    wr(0, 4'hC, 8'h00);
    wr16(4'h2, 16'h5566);
    rd16(4'h2, v); check("R2 high write loads current", {16'd0, v}, 32'h5566);
    wr(0, 4'hC, 8'h00);
    wr(0, 4'h2, 8'h77);
    rd16(4'h2, v); check("R2 low write alone keeps current", {16'd0, v}, 32'h5566);

    // R6 master reset masks everything
    wr(0, 4'hD, 8'h00);
    xfer(2'd1, 16'd1, g, t); check("R6 master reset masks", {16'd0, g}, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule